// File: doc/BRIEF.md
# Opcode-Mapped 16-bit ALU

This block is the arithmetic and logic unit of a small processor. It is purely combinational. It takes two operands, A and B, and a 4-bit operation select, and in the same evaluation it produces a result and a zero flag. The select values are the processor's own instruction opcodes, so the decoder can pass the opcode field straight through without translating it.

The unit covers addition, subtraction, bitwise inversion, logical shifts in both directions by a register amount, AND, OR and a signed set-less-than. The two memory-access opcodes use the adder to form an address. Every select value that has no defined operation also falls back to the adder. The zero flag is taken from the result, and the branch logic uses it to compare two registers.

Width is a parameter with a default of 16. A second parameter picks how the shifter is built: as a staged barrel or as a behavioural shift.

Top module: `opcode_alu`

## Requirements
- R1: Select 4'b0010 gives A+B, wrapping modulo 2^16, with no overflow indication.
- R2: Select 4'b0011 gives A-B, wrapping modulo 2^16, with no overflow indication.
- R3: Select 4'b0100 gives the bitwise inverse of A. The value of B has no effect on the result.
- R4: Select 4'b0101 gives A shifted left by the amount in B, with zeros filled in from bit 0. Any amount of 16 or more gives 0.
- R5: Select 4'b0110 gives A shifted right by the amount in B, with zeros filled in from bit 15. Any amount of 16 or more gives 0.
- R6: Select 4'b0111 gives A AND B, and select 4'b1000 gives A OR B.
- R7: Select 4'b1001 gives 16'h0001 when A is less than B, comparing both as two's-complement signed values. Otherwise it gives 16'h0000.
- R8: Selects 4'b0000 and 4'b0001, the load and store address forms, give A+B modulo 2^16.
- R9: Selects 4'b1010 through 4'b1111 give A+B modulo 2^16.
- R10: The zero flag is 1 exactly when all 16 result bits are 0, whatever the select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select, equal to the processor opcode |
| opnd_a | input | 16 | First operand, A |
| opnd_b | input | 16 | Second operand, B; also the shift amount |
| result | output | 16 | Result of the selected operation |
| zero_flag | output | 1 | 1 when the result is all zeros |

## Verification
The zero flag is produced in the same evaluation as every operation. So it has to be judged together with the results that reach zero by an unusual path: an addition that wraps to zero, a subtraction of equal operands, a shift by 16 or more, a disjoint AND, a false set-less-than, and an undefined select whose sum wraps. The vector table provokes each of these cases. For every vector the bench compares the result and the flag against values written down from the requirements. Sweeps over shift amounts 0 to 20 and over many B values under inversion then check how the flag tracks the edges where the result reaches zero.

// File: rtl/opcode_alu_pkg.sv
package opcode_alu_pkg;

   localparam int OPCODE_W = 4;

   typedef enum logic [OPCODE_W-1:0] {
      SEL_LDADDR = 4'b0000,
      SEL_STADDR = 4'b0001,
      SEL_ADD    = 4'b0010,
      SEL_SUB    = 4'b0011,
      SEL_INV    = 4'b0100,
      SEL_SHL    = 4'b0101,
      SEL_SHR    = 4'b0110,
      SEL_AND    = 4'b0111,
      SEL_OR     = 4'b1000,
      SEL_SLT    = 4'b1001
   } alu_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             do_sub,
   output logic [WIDTH-1:0] arith,
   output logic             signed_lt
);
   logic [WIDTH-1:0] sum_w;
   logic [WIDTH:0]   diff_ext;

   assign sum_w    = a + b;
   assign diff_ext = {a[WIDTH-1], a} - {b[WIDTH-1], b};

   assign arith     = do_sub ? diff_ext[WIDTH-1:0] : sum_w;
   assign signed_lt = diff_ext[WIDTH];

   always_comb begin
      // R1 / R8 / R9: removing B from a wrapped sum recovers A
      if (!do_sub)
         assert_sum_inverse_R1: assert ((arith - b) == a)
            else $error("sum does not invert");
      // R2: adding B back to a wrapped difference recovers A
      if (do_sub)
         assert_diff_inverse_R2: assert ((arith + b) == a)
            else $error("difference does not invert");
      // R7: the sign of the extended difference agrees with a signed compare
      assert_lt_signed_R7: assert (signed_lt == ($signed(a) < $signed(b)))
         else $error("signed compare mismatch");
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] inv_o
);
   assign and_o = a & b;
   assign or_o  = a | b;
   assign inv_o = ~a;

   always_comb begin
      // R6: every bit set in the AND is also set in the OR
      assert_and_within_or_R6: assert ((and_o & ~or_o) == '0)
         else $error("and/or relation broken");
      // R3: the inverse shares no set bit with A, and together they cover every bit
      assert_inv_disjoint_R3: assert (((inv_o & a) == '0) && ((inv_o | a) == '1))
         else $error("inverse not complementary");
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int WIDTH        = 16,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] amt,
   output logic [WIDTH-1:0] shl_o,
   output logic [WIDTH-1:0] shr_o
);
   localparam int              STAGES = $clog2(WIDTH);
   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

   if (STAGED_SHIFT) begin : g_staged
      logic [WIDTH-1:0] lt_st [STAGES+1];
      logic [WIDTH-1:0] rt_st [STAGES+1];
      logic             oversize;

      assign lt_st[0]  = a;
      assign rt_st[0]  = a;
      assign oversize  = (amt >= LIMIT);

      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         assign lt_st[k+1] = amt[k] ? (lt_st[k] << (1 << k)) : lt_st[k];
         assign rt_st[k+1] = amt[k] ? (rt_st[k] >> (1 << k)) : rt_st[k];
      end

      assign shl_o = oversize ? '0 : lt_st[STAGES];
      assign shr_o = oversize ? '0 : rt_st[STAGES];
   end else begin : g_behav
      assign shl_o = (amt >= LIMIT) ? '0 : (a << amt);
      assign shr_o = (amt >= LIMIT) ? '0 : (a >> amt);
   end

   always_comb begin
      // R4 / R5: an amount of zero leaves A as it is
      if (amt == '0)
         assert_shift_zero_R4: assert ((shl_o == a) && (shr_o == a))
            else $error("zero shift altered operand");
      // R4 / R5: an amount at or beyond the width clears both results
      if (amt >= LIMIT)
         assert_shift_clear_R5: assert ((shl_o == '0) && (shr_o == '0))
            else $error("oversized shift not cleared");
      // R4: any nonzero left shift brings a zero into bit 0
      if (amt != '0)
         assert_shl_fill_R4: assert (shl_o[0] == 1'b0)
            else $error("left shift did not fill zero");
   end
endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
   import opcode_alu_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter int OP_W         = 4,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic [OP_W-1:0]  op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag
);
   if (OP_W != OPCODE_W) begin : g_bad_opw
      $error("OP_W must equal the opcode width of the package");
   end
   if (WIDTH < 4) begin : g_bad_width
      $error("WIDTH must be at least 4");
   end

   alu_sel_e         sel;
   logic [WIDTH-1:0] arith_r;
   logic             lt_r;
   logic [WIDTH-1:0] and_r, or_r, inv_r, shl_r, shr_r;

   assign sel = alu_sel_e'(op_sel);

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a         (opnd_a),
      .b         (opnd_b),
      .do_sub    (sel == SEL_SUB),
      .arith     (arith_r),
      .signed_lt (lt_r)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a     (opnd_a),
      .b     (opnd_b),
      .and_o (and_r),
      .or_o  (or_r),
      .inv_o (inv_r)
   );

   alu_shifter #(.WIDTH(WIDTH), .STAGED_SHIFT(STAGED_SHIFT)) u_shift (
      .a     (opnd_a),
      .amt   (opnd_b),
      .shl_o (shl_r),
      .shr_o (shr_r)
   );

   always_comb begin
      unique case (sel)
         SEL_INV: result = inv_r;
         SEL_SHL: result = shl_r;
         SEL_SHR: result = shr_r;
         SEL_AND: result = and_r;
         SEL_OR:  result = or_r;
         SEL_SLT: result = {{(WIDTH-1){1'b0}}, lt_r};
         default: result = arith_r;
      endcase
   end

   assign zero_flag = ~|result;

   always_comb begin
      // R7: a set-less-than result carries at most bit 0
      if (sel == SEL_SLT)
         assert_slt_single_bit_R7: assert ($countones(result) <= 1 && result[WIDTH-1:1] == '0)
            else $error("compare result wider than one bit");
      // R10: the flag and a set bit in the result never appear together
      assert_zero_consistent_R10: assert (!(zero_flag && (result != '0)))
         else $error("zero flag with nonzero result");
      // R8 / R9: the address and undefined selects follow the adder output
      if (!(sel inside {SEL_INV, SEL_SHL, SEL_SHR, SEL_AND, SEL_OR, SEL_SLT, SEL_SUB}))
         assert_fallback_add_R9: assert (result == arith_r)
            else $error("fallback select not routed to adder");
   end
endmodule

// File: tb/sim_opcode_alu.sv
module sim_opcode_alu;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_sel;
   logic [15:0] opnd_a, opnd_b;
   logic [15:0] result;
   logic        zero_flag;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   opcode_alu u0 (
      .op_sel    (op_sel),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .result    (result),
      .zero_flag (zero_flag)
   );

   // {req, op, a, b, expected result, expected zero}
   localparam int NV = 27;
   localparam logic [56:0] VEC [NV] = '{
      {4'd1,  4'h2, 16'h1234, 16'h0101, 16'h1335, 1'b0},  // R1
      {4'd1,  4'h2, 16'h8000, 16'h8000, 16'h0000, 1'b1},  // R1 wrap, R10
      {4'd1,  4'h2, 16'hFFFF, 16'h0002, 16'h0001, 1'b0},  // R1
      {4'd2,  4'h3, 16'h0010, 16'h0003, 16'h000D, 1'b0},  // R2
      {4'd2,  4'h3, 16'h5A5A, 16'h5A5A, 16'h0000, 1'b1},  // R2, R10
      {4'd2,  4'h3, 16'h0000, 16'h0001, 16'hFFFF, 1'b0},  // R2 wrap
      {4'd3,  4'h4, 16'h00FF, 16'h1234, 16'hFF00, 1'b0},  // R3
      {4'd3,  4'h4, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},  // R3, R10
      {4'd4,  4'h5, 16'h0001, 16'h0004, 16'h0010, 1'b0},  // R4
      {4'd4,  4'h5, 16'h8001, 16'h0001, 16'h0002, 1'b0},  // R4
      {4'd4,  4'h5, 16'h1234, 16'h0010, 16'h0000, 1'b1},  // R4 oversize
      {4'd4,  4'h5, 16'hABCD, 16'h0000, 16'hABCD, 1'b0},  // R4
      {4'd5,  4'h6, 16'h8000, 16'h000F, 16'h0001, 1'b0},  // R5
      {4'd5,  4'h6, 16'hF0F0, 16'h0004, 16'h0F0F, 1'b0},  // R5
      {4'd5,  4'h6, 16'hFFFF, 16'h0100, 16'h0000, 1'b1},  // R5 oversize
      {4'd6,  4'h7, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0},  // R6
      {4'd6,  4'h8, 16'hF0F0, 16'h3C3C, 16'hFCFC, 1'b0},  // R6
      {4'd6,  4'h7, 16'h00FF, 16'hFF00, 16'h0000, 1'b1},  // R6, R10
      {4'd7,  4'h9, 16'h0003, 16'h0005, 16'h0001, 1'b0},  // R7
      {4'd7,  4'h9, 16'hFFFF, 16'h0001, 16'h0001, 1'b0},  // R7 signed
      {4'd7,  4'h9, 16'h0001, 16'hFFFF, 16'h0000, 1'b1},  // R7 signed
      {4'd7,  4'h9, 16'h7FFF, 16'h8000, 16'h0000, 1'b1},  // R7
      {4'd7,  4'h9, 16'h0042, 16'h0042, 16'h0000, 1'b1},  // R7 equal
      {4'd8,  4'h0, 16'h0010, 16'h0004, 16'h0014, 1'b0},  // R8
      {4'd8,  4'h1, 16'hFFFE, 16'h0003, 16'h0001, 1'b0},  // R8
      {4'd9,  4'hA, 16'h0100, 16'h0023, 16'h0123, 1'b0},  // R9
      {4'd9,  4'hF, 16'hFFFF, 16'h0001, 16'h0000, 1'b1}   // R9, R10
   };

   task automatic check(input string tag, input logic [15:0] exp_r, input logic exp_z);
      checks++;
      if (result !== exp_r || zero_flag !== exp_z) begin
         errors++;
         $display("FAIL %s: op=%h a=%h b=%h got result=%h zero=%b expected result=%h zero=%b",
                  tag, op_sel, opnd_a, opnd_b, result, zero_flag, exp_r, exp_z);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      op_sel = op; opnd_a = a; opnd_b = b;
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      op_sel = 4'h0; opnd_a = '0; opnd_b = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #1;
      // idle inputs after reset: address form of 0+0, so R8 and R10
      check("R8 idle", 16'h0000, 1'b1);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][52:49], VEC[i][48:33], VEC[i][32:17]);
         check($sformatf("R%0d vector %0d", VEC[i][56:53], i), VEC[i][16:1], VEC[i][0]);
      end

      // R3: B has no effect on the inverse
      for (int k = 0; k < 16; k++) begin
         apply(4'h4, 16'h3C0F, 16'(k * 16'h1111 + 16'h0F0F * k));
         check("R3 ignores B", 16'hC3F0, 1'b0);
      end

      // R4 / R5: every shift amount from 0 to 20
      for (int s = 0; s <= 20; s++) begin
         logic [15:0] exl, exr;
         exl = (s >= 16) ? 16'h0 : 16'(16'h8421 << s);
         exr = (s >= 16) ? 16'h0 : 16'(16'h8421 >> s);
         apply(4'h5, 16'h8421, 16'(s));
         check("R4 sweep", exl, exl == 16'h0);
         apply(4'h6, 16'h8421, 16'(s));
         check("R5 sweep", exr, exr == 16'h0);
      end

      // R9: each undefined select adds
      for (int o = 10; o < 16; o++) begin
         apply(4'(o), 16'h7000, 16'h0ABC);
         check("R9 fallback", 16'h7ABC, 1'b0);
      end

      // R10: single-bit results never raise the flag
      apply(4'h6, 16'h8000, 16'h000F);
      check("R10 one bit", 16'h0001, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule